// File: doc/BRIEF.md
# Hashed Neighbour Address Filter

This block tells a receive path whether the source address of an incoming frame belongs to a node that is currently associated. It holds its own small table of neighbour addresses, so the verdict can be reached without waking the main processor. A frame that misses can then be dropped at once. The table takes both 16-bit short addresses and 64-bit extended addresses in the same storage.

The table is not scanned line by line. Each key is hashed to a home slot. The search then probes a short run of slots starting there. The same port serves lookups and processor updates. Software inserts an entry when a node joins and deletes it when the node leaves. A deleted slot becomes a tombstone, so entries stored past it in the same run can still be found. One operation runs at a time. A request is accepted only while the block is idle.

Top module: `nbr_addr_filter`

## Requirements
- R1: After reset the block is idle (`busy`=0, `done`=0) and every slot is empty, so any lookup misses after examining one slot.
- R2: The key is formed from `ext` and `addr`. When `ext`=0 it is `addr[15:0]` zero-extended, and `addr[63:16]` is ignored. When `ext`=1 all 64 bits are used. A stored entry matches only when both its key and its `ext` mode equal the request, so a short address never matches an extended one of the same value.
- R3: The home slot is the XOR of the key's 7-bit chunks (chunk i = key bits 7i..7i+6, with the last chunk holding bit 63 alone) XOR `ext` in bit 0. Probe k, for k = 0..7, examines slot (home + k) mod 128, so the run wraps from slot 127 to slot 0.
- R4: The operation code `op` is 00 for lookup, 01 for insert, 10 for delete and 11 for lookup. Every operation ends with `done` high for exactly one cycle. That cycle follows n rising edges after the accepting edge, where n is the number of slots examined. On a lookup, `hit`=1 means a live matching entry was found, and `err` is 0.
- R5: A lookup stops with a miss at the first empty slot. It also stops with a miss after eight slots if none of them matched.
- R6: An insert of a key that is already present returns `hit`=1 and `err`=0 and writes nothing. Otherwise it stores the key in the first tombstone of the run, or in the first empty slot if no tombstone came before it. If all eight slots hold other live entries, it returns `err`=1.
- R7: A delete turns the matching live slot into a tombstone and returns `hit`=1. Later probes continue past a tombstone. A delete of a key that is absent returns `err`=1.
- R8: A request presented while `busy`=1 is ignored and changes no table state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start an operation (taken only when idle) |
| op | input | 2 | 00/11 lookup, 01 insert, 10 delete |
| ext | input | 1 | 1 = 64-bit address, 0 = 16-bit address |
| addr | input | 64 | Address operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| hit | output | 1 | Key found (valid with done) |
| err | output | 1 | Insert window full or delete target absent (valid with done) |

## Verification
Each result is due a fixed number of edges after the accepting edge. That number equals the count of slots the search examines: one for an empty home slot, eight for a full run, and the tombstone position for a reused slot. The bench works out this count from the slot layout it has built. It then counts falling edges from the request until `done` appears and compares the count with the expected value. The verdict and the error flag are read on that same falling edge. To test that requests are ignored while busy, an insert is pulsed partway through a long lookup. A later one-probe lookup shows that the insert never took effect.

// File: rtl/nbr_addr_filter.sv
module nbr_addr_filter #(
  parameter int ENTRIES = 128,
  parameter int PROBES  = 8,
  parameter int AW      = 64,
  parameter int SW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [1:0]    op,
  input  logic          ext,
  input  logic [AW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic          hit,
  output logic          err
);
  localparam int IW     = $clog2(ENTRIES);
  localparam int CW     = $clog2(PROBES);
  localparam int CHUNKS = (AW + IW - 1) / IW;

  function automatic logic [IW-1:0] fold(input logic [AW-1:0] k, input logic e);
    logic [IW*CHUNKS-1:0] p;
    logic [IW-1:0] h;
    p = '0;
    p[AW-1:0] = k;
    h = {{(IW-1){1'b0}}, e};
    for (int i = 0; i < CHUNKS; i++) h ^= p[i*IW +: IW];
    return h;
  endfunction

  logic [ENTRIES-1:0] live_q, tomb_q, mode_q;
  logic [AW-1:0]      key_q [ENTRIES];

  logic [1:0]    op_q;
  logic          ext_q;
  logic [AW-1:0] key_r;
  logic [IW-1:0] base_q, fr_idx_q;
  logic [CW-1:0] cnt_q;
  logic          fr_ok_q;

  wire [AW-1:0] key_in = ext ? addr : {{(AW-SW){1'b0}}, addr[SW-1:0]};
  wire [IW-1:0] idx    = base_q + IW'(cnt_q);
  wire slot_empty = !live_q[idx] && !tomb_q[idx];
  wire slot_match = live_q[idx] && (mode_q[idx] == ext_q) && (key_q[idx] == key_r);
  wire last       = (cnt_q == CW'(PROBES - 1));

  logic fin, f_hit, f_err, wr, kill;
  logic [IW-1:0] wr_idx;

  always_comb begin
    fin = 1'b0; f_hit = 1'b0; f_err = 1'b0; wr = 1'b0; kill = 1'b0;
    wr_idx = fr_ok_q ? fr_idx_q : idx;
    unique case (op_q)
      2'b01: begin
        if (slot_match) begin
          fin = 1'b1; f_hit = 1'b1;
        end else if (slot_empty || (last && (fr_ok_q || tomb_q[idx]))) begin
          fin = 1'b1; wr = 1'b1;
        end else if (last) begin
          fin = 1'b1; f_err = 1'b1;
        end
      end
      2'b10: begin
        if (slot_match) begin
          fin = 1'b1; f_hit = 1'b1; kill = 1'b1;
        end else if (slot_empty || last) begin
          fin = 1'b1; f_err = 1'b1;
        end
      end
      default: begin
        if (slot_match) begin
          fin = 1'b1; f_hit = 1'b1;
        end else if (slot_empty || last) begin
          fin = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; hit <= 1'b0; err <= 1'b0;
      live_q <= '0; tomb_q <= '0;
      op_q <= 2'b00; ext_q <= 1'b0; key_r <= '0; base_q <= '0;
      cnt_q <= '0; fr_ok_q <= 1'b0; fr_idx_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req) begin
          busy <= 1'b1; op_q <= op; ext_q <= ext; key_r <= key_in;
          base_q <= fold(key_in, ext); cnt_q <= '0; fr_ok_q <= 1'b0;
        end
      end else if (fin) begin
        busy <= 1'b0; done <= 1'b1; hit <= f_hit; err <= f_err;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (tomb_q[idx] && !fr_ok_q) begin
          fr_ok_q <= 1'b1; fr_idx_q <= idx;
        end
      end
      if (busy && wr) begin
        live_q[wr_idx] <= 1'b1; tomb_q[wr_idx] <= 1'b0;
      end
      if (busy && kill) begin
        live_q[idx] <= 1'b0; tomb_q[idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && wr) begin
      key_q[wr_idx]  <= key_r;
      mode_q[wr_idx] <= ext_q;
    end
  end

  logic [CW:0] bcyc_q;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) bcyc_q <= '0;
    else                 bcyc_q <= bcyc_q + 1'b1;
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R4
  lookup_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == 2'b00 || op_q == 2'b11)) |-> !err);
  // R5
  probe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcyc_q < (CW+1)'(PROBES)));
  // R7
  tomb_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(live_q[idx] && tomb_q[idx]));
  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);
  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> ($stable(key_r) && $stable(op_q) && $stable(base_q)));
endmodule

// File: tb/nbr_addr_filter_bench.sv
`timescale 1ns/1ps
module nbr_addr_filter_bench;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, ext = 1'b0;
  logic [1:0] op = 2'b00;
  logic [63:0] addr = '0;
  logic busy, done, hit, err;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  nbr_addr_filter u_nbr_addr_filter (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .ext(ext), .addr(addr),
    .busy(busy), .done(done), .hit(hit), .err(err));

  localparam logic [1:0] LK = 2'b00, INS = 2'b01, DEL = 2'b10, LK3 = 2'b11;

  function automatic logic [63:0] kc(input int i);
    return {48'h0, 16'h0010 ^ 16'(i | (i << 7))};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic e, input logic [63:0] a,
                        output logic h, output logic er, output int lat);
    @(negedge clk); req = 1'b1; op = o; ext = e; addr = a;
    @(negedge clk); req = 1'b0;
    lat = 0; h = 1'b0; er = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); lat++;
      if (done) begin h = hit; er = err; break; end
    end
    if (lat >= 20) chk(1'b0, "R4 no done", lat, 0);
  endtask

  task automatic expect_op(input string tag, input logic [1:0] o, input logic e,
                           input logic [63:0] a, input logic eh, input logic ee, input int el);
    logic h, er; int lat;
    run_op(o, e, a, h, er, lat);
    chk(h == eh, {tag, " hit"}, int'(h), int'(eh));
    chk(er == ee, {tag, " err"}, int'(er), int'(ee));
    if (el > 0) chk(lat == el, {tag, " latency"}, lat, el);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    expect_op("R1 empty lookup", LK, 1'b0, kc(0), 1'b0, 1'b0, 1);
  endtask

  task automatic t_modes;
    expect_op("R2 insert short", INS, 1'b0, 64'hABCD, 1'b0, 1'b0, 1);
    expect_op("R2 upper bits ignored", LK, 1'b0, 64'hFFFF_FFFF_FFFF_ABCD, 1'b1, 1'b0, 1);
    expect_op("R2 ext vs short", LK, 1'b1, 64'hABCD, 1'b0, 1'b0, 1);
    expect_op("R2 insert ext", INS, 1'b1, 64'hA000_0000_0000_0000, 1'b0, 1'b0, 1);
    expect_op("R2 lookup ext", LK, 1'b1, 64'hA000_0000_0000_0000, 1'b1, 1'b0, 1);
    expect_op("R2 ext differs high", LK, 1'b1, 64'h2000_0000_0000_0000, 1'b0, 1'b0, 1);
  endtask

  task automatic t_collide;
    for (int i = 0; i < 8; i++)
      expect_op("R6 fill run", INS, 1'b0, kc(i), 1'b0, 1'b0, i + 1);
    expect_op("R6 run full", INS, 1'b0, kc(8), 1'b0, 1'b1, 8);
    expect_op("R3 probe depth", LK, 1'b0, kc(7), 1'b1, 1'b0, 8);
    expect_op("R5 miss after window", LK, 1'b0, kc(8), 1'b0, 1'b0, 8);
    expect_op("R6 duplicate", INS, 1'b0, kc(0), 1'b1, 1'b0, 1);
  endtask

  task automatic t_delete;
    expect_op("R7 delete", DEL, 1'b0, kc(3), 1'b1, 1'b0, 4);
    expect_op("R7 past tombstone", LK, 1'b0, kc(5), 1'b1, 1'b0, 6);
    expect_op("R7 deleted gone", LK, 1'b0, kc(3), 1'b0, 1'b0, 8);
    expect_op("R7 delete absent", DEL, 1'b0, kc(3), 1'b0, 1'b1, 8);
    expect_op("R6 reuse tombstone", INS, 1'b0, kc(8), 1'b0, 1'b0, 8);
    expect_op("R6 reused slot", LK, 1'b0, kc(8), 1'b1, 1'b0, 4);
  endtask

  task automatic t_wrap;
    expect_op("R3 wrap home", INS, 1'b0, 64'h007F, 1'b0, 1'b0, 1);
    expect_op("R3 wrap next", INS, 1'b0, 64'h00FE, 1'b0, 1'b0, 2);
    expect_op("R3 wrap lookup", LK, 1'b0, 64'h00FE, 1'b1, 1'b0, 2);
    expect_op("R4 op 11 is lookup", LK3, 1'b0, 64'h00FE, 1'b1, 1'b0, 2);
  endtask

  task automatic t_busy;
    int lat; logic h;
    @(negedge clk); req = 1'b1; op = LK; ext = 1'b0; addr = kc(9);
    @(negedge clk); req = 1'b0;
    lat = 0; h = 1'b1;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk); lat++;
      req = (lat == 2); op = INS; addr = 64'h5555;
      if (done) begin h = hit; break; end
    end
    req = 1'b0;
    chk(h == 1'b0, "R8 long lookup hit", int'(h), 0);
    chk(lat == 8, "R8 long lookup latency", lat, 8);
    expect_op("R8 busy insert ignored", LK, 1'b0, 64'h5555, 1'b0, 1'b0, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_modes;
    t_collide;
    t_delete;
    t_wrap;
    t_busy;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule